// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Framing Recovery

This block turns a single asynchronous serial line into a stream of characters. An external enable, `os_tick`, pulses sixteen times per bit period. The line is synchronised into the clock domain first. A state machine then finds the start bit, samples each bit near its middle and builds a character of 5 to 8 data bits. It can check an optional parity bit against the even or odd setting and expects one stop bit. Each finished character is offered to a downstream receive FIFO as a one-cycle `push_valid` strobe. The strobe carries the data and three tags: parity error, framing error and break.

Two line conditions need special handling. A line held at the spacing level (0) for at least a full character time is a break. It produces exactly one all-zero character tagged as a break. The receiver then waits for the line to return to 1 before it looks for a new start bit. A character whose stop bit reads 0, but which is not a break, is tagged with a framing error. The receiver assumes that low stop period is really the next start bit. It checks the line once more on the next tick and, if the line is still low, goes straight on to the data bits.

The state machine has eight states:
- IDLE waits for a low sample, then goes to START.
- START goes to DATA if the line is still low on the eighth tick, and back to IDLE if it is high.
- DATA goes to PARITY or STOP after the last data bit.
- PARITY goes to STOP.
- STOP goes to IDLE if the stop bit is good. It goes to BRKCHK if the stop bit is low and every earlier bit was low. It goes to RESYNC on any other low stop bit.
- BRKCHK goes to BRKWAIT, pushing a break, once the line has stayed low for the rest of the stop bit. If the line rises first, it goes to IDLE and pushes a framing error.
- RESYNC goes to DATA if the line is still low and to IDLE if it is high.
- BRKWAIT goes to IDLE once the line is high.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is asserted and after its release on an idle high line, `push_valid` and `overrun` stay 0.
- R2: `cfg_width` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are received LSB first into `push_data` bit 0 upward, and the unused upper bits read 0.
- R3: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_even`=1 the XOR of the data and parity bits must be 0; with it at 0 that XOR must be 1. A mismatch sets `push_perr`. With parity disabled `push_perr` is always 0.
- R4: A low pulse that is high again by the eighth tick after detection is a false start and produces no character.
- R5: A stop bit sampled at 0 after a character that has at least one 1 bit sets `push_ferr` on that character.
- R6: After a framing error the low stop period is taken as the next start bit. It is re-checked on the next tick and, if still low, the following bits are received as a new character.
- R7: A line held low from the start bit through the end of the stop bit pushes one character with data 0, `push_brk`=1 and both error tags 0.
- R8: A break pushes exactly one character however long it lasts. Reception resumes with the next start bit after the line returns high.
- R9: An all-zero character whose line returns high during the second half of its stop bit is pushed with `push_ferr`=1 and `push_brk`=0, and produces no further character.
- R10: If `fifo_full` is 1 when a character completes, `overrun` pulses for one cycle and no `push_valid` is given for that character.
- R11: Each received character gives `push_valid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_width | input | 2 | Data bit count select, 5 + value |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| fifo_full | input | 1 | Downstream FIFO cannot accept a push |
| push_valid | output | 1 | One-cycle strobe for a completed character |
| push_data | output | 8 | Received data, zero-filled above the width |
| push_perr | output | 1 | Parity error tag |
| push_ferr | output | 1 | Framing error tag |
| push_brk | output | 1 | Break tag |
| overrun | output | 1 | Character dropped because the FIFO was full |

## Verification
The bench builds the block with its defaults: sixteen ticks per bit and a two-stage synchroniser. It supplies one tick every four clocks, so a bit lasts 64 clocks. That short bit time makes break runs of twenty or more bit periods, and full recovery after them, cheap to cover. It also places the start-bit check, the break check in the second half of the stop bit and the one-tick re-check after a framing error at offsets the bench can hit with margin on both sides. All four data widths and both parity senses are reached by changing the configuration inputs between frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned CHAR_W   = 8;
    localparam int unsigned MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKCHK,
        ST_RESYNC,
        ST_BRKWAIT
    } rx_state_e;

    // Number of data bits for a width select code.
    function automatic logic [3:0] width_of(input logic [1:0] sel);
        return 4'(MIN_BITS) + {2'b00, sel};
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              data_en,
    input  logic              par_en,
    input  logic              bit_in,
    input  logic [1:0]        width_sel,
    output logic [CHAR_W-1:0] data,
    output logic              par_bit,
    output logic              all_zero,
    output logic              data_xor
);
    logic [CHAR_W-1:0] sr;
    logic [3:0]        align;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= '0;
            par_bit  <= 1'b0;
            all_zero <= 1'b1;
        end else if (clear) begin
            sr       <= '0;
            par_bit  <= 1'b0;
            all_zero <= 1'b1;
        end else begin
            if (data_en) sr <= {bit_in, sr[CHAR_W-1:1]};
            if (par_en)  par_bit <= bit_in;
            if ((data_en || par_en) && bit_in) all_zero <= 1'b0;
        end
    end

    // Bits enter at the top; right-align for narrower characters.
    assign align    = 4'(CHAR_W) - width_of(width_sel);
    assign data     = sr >> align;
    assign data_xor = ^data;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              fifo_full,
    output logic              push_valid,
    output logic [CHAR_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr,
    output logic              push_brk,
    output logic              overrun
);
    localparam int              CNT_W    = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OS_RATE - 1);

    rx_state_e          state, nxt_state;
    logic [CNT_W-1:0]   cnt, nxt_cnt;
    logic [2:0]         idx, nxt_idx;
    logic [2:0]         last_idx;
    logic               rx_s;
    logic               sh_clear, sh_data, sh_par;
    logic [CHAR_W-1:0]  sh_val;
    logic               sh_parbit, sh_zero, sh_xor;
    logic               ev_done, ev_ferr, ev_brk;
    logic               perr_calc;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    uart_rx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .data_en   (sh_data),
        .par_en    (sh_par),
        .bit_in    (rx_s),
        .width_sel (cfg_width),
        .data      (sh_val),
        .par_bit   (sh_parbit),
        .all_zero  (sh_zero),
        .data_xor  (sh_xor)
    );

    assign last_idx  = 3'(width_of(cfg_width) - 4'd1);
    assign perr_calc = cfg_par_en && (sh_xor ^ sh_parbit ^ !cfg_par_even);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            idx   <= nxt_idx;
        end
    end

    // Next state and sampling events.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_idx   = idx;
        sh_clear  = 1'b0;
        sh_data   = 1'b0;
        sh_par    = 1'b0;
        ev_done   = 1'b0;
        ev_ferr   = 1'b0;
        ev_brk    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (os_tick && !rx_s) begin
                    nxt_state = ST_START;
                    nxt_cnt   = '0;
                end
            end
            ST_START: begin
                if (os_tick) begin
                    if (cnt == MID_LAST) begin
                        if (rx_s) begin
                            nxt_state = ST_IDLE;
                        end else begin
                            nxt_state = ST_DATA;
                            nxt_cnt   = '0;
                            nxt_idx   = '0;
                            sh_clear  = 1'b1;
                        end
                    end else begin
                        nxt_cnt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (os_tick) begin
                    if (cnt == BIT_LAST) begin
                        sh_data = 1'b1;
                        nxt_cnt = '0;
                        if (idx == last_idx)
                            nxt_state = cfg_par_en ? ST_PARITY : ST_STOP;
                        else
                            nxt_idx = idx + 3'd1;
                    end else begin
                        nxt_cnt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (os_tick) begin
                    if (cnt == BIT_LAST) begin
                        sh_par    = 1'b1;
                        nxt_cnt   = '0;
                        nxt_state = ST_STOP;
                    end else begin
                        nxt_cnt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (os_tick) begin
                    if (cnt == BIT_LAST) begin
                        nxt_cnt = '0;
                        if (rx_s) begin
                            ev_done   = 1'b1;
                            nxt_state = ST_IDLE;
                        end else if (sh_zero) begin
                            nxt_state = ST_BRKCHK;
                        end else begin
                            ev_done   = 1'b1;
                            ev_ferr   = 1'b1;
                            nxt_state = ST_RESYNC;
                        end
                    end else begin
                        nxt_cnt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_BRKCHK: begin
                if (os_tick) begin
                    if (rx_s) begin
                        ev_done   = 1'b1;
                        ev_ferr   = 1'b1;
                        nxt_state = ST_IDLE;
                    end else if (cnt == MID_LAST) begin
                        ev_done   = 1'b1;
                        ev_brk    = 1'b1;
                        nxt_state = ST_BRKWAIT;
                    end else begin
                        nxt_cnt = cnt + CNT_W'(1);
                    end
                end
            end
            ST_RESYNC: begin
                if (os_tick) begin
                    if (rx_s) begin
                        nxt_state = ST_IDLE;
                    end else begin
                        nxt_state = ST_DATA;
                        nxt_cnt   = CNT_W'(1);
                        nxt_idx   = '0;
                        sh_clear  = 1'b1;
                    end
                end
            end
            ST_BRKWAIT: begin
                if (os_tick && rx_s) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            overrun    <= 1'b0;
            push_data  <= '0;
            push_perr  <= 1'b0;
            push_ferr  <= 1'b0;
            push_brk   <= 1'b0;
        end else begin
            push_valid <= ev_done && !fifo_full;
            overrun    <= ev_done && fifo_full;
            if (ev_done) begin
                push_data <= ev_brk ? '0 : sh_val;
                push_perr <= !ev_brk && perr_calc;
                push_ferr <= ev_ferr;
                push_brk  <= ev_brk;
            end
        end
    end
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_width,
    input logic              cfg_par_en,
    input logic              fifo_full,
    input logic              push_valid,
    input logic [CHAR_W-1:0] push_data,
    input logic              push_perr,
    input logic              push_ferr,
    input logic              push_brk,
    input logic              overrun
);
    p_one_cycle_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);

    p_drop_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(fifo_full) && !push_valid));

    p_push_when_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !$past(fifo_full));

    p_break_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_brk) |-> (push_data == '0 && !push_ferr && !push_perr));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> ((push_data >> width_of(cfg_width)) == '0));

    p_perr_needs_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_perr) |-> cfg_par_en);
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width),
    .cfg_par_en (cfg_par_en),
    .fifo_full  (fifo_full),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_perr  (push_perr),
    .push_ferr  (push_ferr),
    .push_brk   (push_brk),
    .overrun    (overrun)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
    localparam int BITCLK = 64;
    localparam int NV     = 9;
    // {width_sel[12:11], par_en[10], par_even[9], flip_parity[8], data[7:0]}
    localparam logic [12:0] VEC [NV] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd0, 1'b0, 1'b0, 1'b0, 8'h15},
        {2'd1, 1'b1, 1'b1, 1'b0, 8'h2B},
        {2'd2, 1'b1, 1'b0, 1'b0, 8'h55},
        {2'd3, 1'b1, 1'b1, 1'b1, 8'hC3},
        {2'd0, 1'b1, 1'b0, 1'b1, 8'h1F},
        {2'd3, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'd2, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'd1, 1'b1, 1'b1, 1'b1, 8'h3F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_width = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       fifo_full = 1'b0;
    logic       push_valid;
    logic [7:0] push_data;
    logic       push_perr, push_ferr, push_brk, overrun;

    uart_rx_core dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rxd          (rxd),
        .cfg_width    (cfg_width),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .fifo_full    (fifo_full),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .push_perr    (push_perr),
        .push_ferr    (push_ferr),
        .push_brk     (push_brk),
        .overrun      (overrun)
    );

    always #2 clk = ~clk;

    logic [1:0] tdiv = 2'd0;
    always @(posedge clk) begin
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    logic [10:0] cap [64];
    int cap_n = 0;
    int ovr_n = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (push_valid) begin
                if (cap_n < 64) cap[cap_n] = {push_brk, push_ferr, push_perr, push_data};
                cap_n++;
            end
            if (overrun) ovr_n++;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    function automatic logic [7:0] mask_of(input logic [7:0] d, input int n);
        return d & 8'((1 << n) - 1);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input int n, input logic even);
        logic x;
        x = ^mask_of(d, n);
        return even ? x : ~x;
    endfunction

    task automatic send_frame(input logic [1:0] sel, input logic pen, input logic even,
                              input logic [7:0] d, input logic flip, input logic stop_v);
        int n;
        n = 5 + int'(sel);
        cfg_width    = sel;
        cfg_par_en   = pen;
        cfg_par_even = even;
        hold(1'b0, BITCLK);
        for (int i = 0; i < n; i++) hold(d[i], BITCLK);
        if (pen) hold(par_of(d, n, even) ^ flip, BITCLK);
        hold(stop_v, BITCLK);
        rxd = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin
        int base;
        int ob;
        logic [12:0] v;
        logic [10:0] exp;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(push_valid == 1'b0 && overrun == 1'b0, "R1 in reset", {push_valid, overrun}, 0);
        rst_n = 1'b1;
        hold(1'b1, BITCLK * 3);
        check(cap_n == 0 && ovr_n == 0, "R1 idle after reset", cap_n, 0);

        // Table of frames: R2, R3, R11
        for (int k = 0; k < NV; k++) begin
            v    = VEC[k];
            base = cap_n;
            send_frame(v[12:11], v[10], v[9], v[7:0], v[8], 1'b1);
            hold(1'b1, BITCLK * 2);
            exp = {1'b0, 1'b0, v[10] & v[8], mask_of(v[7:0], 5 + int'(v[12:11]))};
            check(cap_n == base + 1, "R11 one push per frame", cap_n - base, 1);
            check(cap[base] === exp, "R2 R3 frame contents", cap[base], exp);
        end

        // R4: false start
        cfg_width  = 2'd3;
        cfg_par_en = 1'b0;
        base = cap_n;
        hold(1'b0, 16);
        hold(1'b1, BITCLK * 12);
        check(cap_n == base, "R4 false start ignored", cap_n - base, 0);

        // R5, R6: framing error and resync
        base = cap_n;
        send_frame(2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0);
        hold(1'b1, BITCLK * 12);
        check(cap_n == base + 2, "R6 resync char count", cap_n - base, 2);
        check(cap[base] === {3'b010, 8'h5A}, "R5 framing tag", cap[base], {3'b010, 8'h5A});
        check(cap[base + 1] === {3'b000, 8'hFF}, "R6 resync contents", cap[base + 1], {3'b000, 8'hFF});

        // R7, R8: long break, 8 bits no parity
        base = cap_n;
        hold(1'b0, BITCLK * 25);
        check(cap_n == base + 1, "R8 single break push", cap_n - base, 1);
        check(cap[base] === {3'b100, 8'h00}, "R7 break contents", cap[base], {3'b100, 8'h00});
        hold(1'b1, BITCLK * 2);
        send_frame(2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1);
        hold(1'b1, BITCLK * 2);
        check(cap_n == base + 2, "R8 resume after break", cap_n - base, 2);
        check(cap[base + 1] === {3'b000, 8'hA5}, "R8 char after break", cap[base + 1], {3'b000, 8'hA5});

        // R7: break with 5 bits and odd parity
        cfg_width    = 2'd0;
        cfg_par_en   = 1'b1;
        cfg_par_even = 1'b0;
        base = cap_n;
        hold(1'b0, BITCLK * 20);
        hold(1'b1, BITCLK * 3);
        check(cap_n == base + 1, "R8 single break push parity", cap_n - base, 1);
        check(cap[base] === {3'b100, 8'h00}, "R7 break with parity", cap[base], {3'b100, 8'h00});

        // R9: zero char, line recovers inside the stop bit
        cfg_width  = 2'd3;
        cfg_par_en = 1'b0;
        base = cap_n;
        hold(1'b0, BITCLK * 9);
        hold(1'b0, 44);
        hold(1'b1, BITCLK * 12);
        check(cap_n == base + 1, "R9 one push", cap_n - base, 1);
        check(cap[base] === {3'b010, 8'h00}, "R9 framing not break", cap[base], {3'b010, 8'h00});

        // R10: overrun
        fifo_full = 1'b1;
        base = cap_n;
        ob   = ovr_n;
        send_frame(2'd3, 1'b0, 1'b0, 8'h33, 1'b0, 1'b1);
        hold(1'b1, BITCLK * 2);
        check(cap_n == base, "R10 no push when full", cap_n - base, 0);
        check(ovr_n == ob + 1, "R10 overrun pulse", ovr_n - ob, 1);
        fifo_full = 1'b0;
        base = cap_n;
        send_frame(2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1);
        hold(1'b1, BITCLK * 2);
        check(cap_n == base + 1 && cap[base] === {3'b000, 8'h3C}, "R10 push after full clears",
              cap[base], {3'b000, 8'h3C});

        finish_run();
    end
endmodule